// File: doc/BRIEF.md
# Fragment Group Completeness Filter

This block sits at the end of a beam summing chain. Upstream stages deliver packet fragments, each tagged with a position index from 0 to 7. Eight fragments with all eight indices make one output packet. The block collects the fragments of each group into a slot buffer. When the group closes, it emits the whole packet as one wide word in a single cycle, or it drops the packet. Missing fragments are counted in fragment units.

A mode input selects how an incomplete group is handled. In discard mode the group is dropped whole and the loss counter rises by eight. In flag mode every missing slot is filled with an all-ones word and marked by a per-slot flag bit, the packet is forwarded, and the counter rises by the number of filled slots. The counter clears when it is read and saturates instead of wrapping. Only the final stage of the chain counts. A parameter turns counting off on other stages, so they always read zero.

Top module: `frag_filter`

## Requirements
- R1: A forwarded packet appears on `pkt_data_o` for one cycle, in the cycle after the edge that closed its group. Fragment index k occupies bits [k*W +: W]. A group is complete when all indices 0..7 were received.
- R2: A valid fragment with index 7 closes the current group, and that fragment is part of the group.
- R3: A valid fragment whose index is lower than or equal to the last accepted index of an open group closes that group without itself. It then opens a new group holding only that fragment.
- R4: An open group closes on the TMO_CYC-th consecutive clock edge with no valid fragment.
- R5: In discard mode (`flag_en_i`=0), a complete group is forwarded with `pkt_flag_o`=0. An incomplete group produces no packet and adds 8 to the counter.
- R6: In flag mode (`flag_en_i`=1), every closed group is forwarded. Each missing slot carries all ones with its bit set in `pkt_flag_o` (bit k for index k). The counter rises by the number of missing slots.
- R7: The mode applied to a group is the value of `flag_en_i` in the cycle that group closes.
- R8: While `cnt_rd_i` is high, `cnt_o` shows the count being read. After that edge the count holds only the increment that arrived in the same cycle.
- R9: The counter saturates at 2^CNT_W-1 (32 bits by default) and does not wrap.
- R10: With FINAL_STAGE=0, `cnt_o` is always 0 while packets are still filtered and forwarded.
- R11: After reset no packet is output, the counter is 0 and no group is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frag_valid_i | input | 1 | Fragment present this cycle |
| frag_idx_i | input | 3 | Fragment position within its group |
| frag_data_i | input | W | Fragment payload |
| flag_en_i | input | 1 | 1 = fill and flag missing slots, 0 = drop incomplete groups |
| pkt_valid_o | output | 1 | Packet output strobe |
| pkt_data_o | output | 8*W | Reassembled packet, slot k at [k*W +: W] |
| pkt_flag_o | output | 8 | Per-slot substitution flags |
| cnt_rd_i | input | 1 | Read strobe; clears the counter |
| cnt_o | output | CNT_W | Dropped or substituted fragment count |

## Verification
The assertions check the following on every cycle:
- an index-7 fragment empties the group;
- a backward index leaves exactly that one slot open;
- a discard-mode packet never carries flags;
- a saturated count holds without a read;
- a read leaves only the increment from the same cycle.

The bench scenarios are needed for the rest:
- the exact timeout edge;
- filler contents and flag masks for varied gap patterns;
- the mode being sampled at close rather than at open;
- a non-final stage staying at zero while it still forwards packets.

// File: rtl/frag_pkg.sv
package frag_pkg;
  localparam int unsigned FRAGS = 8;
  localparam int unsigned IDX_W = 3;
  localparam int unsigned ADD_W = 4;

  typedef logic [FRAGS-1:0] slot_mask_t;

  function automatic logic [ADD_W-1:0] popcnt(input slot_mask_t m);
    logic [ADD_W-1:0] n;
    n = '0;
    for (int i = 0; i < FRAGS; i++) n = n + ADD_W'(m[i]);
    return n;
  endfunction
endpackage

// File: rtl/frag_collector.sv
module frag_collector
  import frag_pkg::*;
#(
  parameter int unsigned W       = 16,
  parameter int unsigned TMO_CYC = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_v_i,
  input  logic [IDX_W-1:0]     in_idx_i,
  input  logic [W-1:0]         in_data_i,
  output logic                 close_o,
  output slot_mask_t           cmask_o,
  output logic [FRAGS*W-1:0]   cdata_o
);
  localparam int unsigned TMO_W = $clog2(TMO_CYC + 1);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_CYC - 1);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(FRAGS - 1);

  logic [FRAGS*W-1:0] data_q;
  slot_mask_t         mask_q;
  logic [IDX_W-1:0]   last_q;
  logic [TMO_W-1:0]   tmo_q;

  logic open_w, hit_top, back, tmo_hit;
  slot_mask_t in_bit;

  assign open_w  = |mask_q;
  assign in_bit  = slot_mask_t'(1) << in_idx_i;
  assign hit_top = in_v_i && (in_idx_i == IDX_TOP);
  assign back    = in_v_i && open_w && (in_idx_i <= last_q) && !hit_top;
  assign tmo_hit = !in_v_i && open_w && (tmo_q == TMO_LAST);
  assign close_o = hit_top || back || tmo_hit;
  assign cmask_o = hit_top ? (mask_q | in_bit) : mask_q;

  for (genvar k = 0; k < FRAGS; k++) begin : g_cdata
    if (k == FRAGS - 1) begin : g_top
      assign cdata_o[k*W +: W] = hit_top ? in_data_i : data_q[k*W +: W];
    end else begin : g_low
      assign cdata_o[k*W +: W] = data_q[k*W +: W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      mask_q <= '0;
      last_q <= '0;
      tmo_q  <= '0;
    end else if (in_v_i) begin
      data_q[in_idx_i*W +: W] <= in_data_i;
      last_q <= in_idx_i;
      tmo_q  <= '0;
      if (hit_top)   mask_q <= '0;
      else if (back) mask_q <= in_bit;
      else           mask_q <= mask_q | in_bit;
    end else if (tmo_hit) begin
      mask_q <= '0;
      tmo_q  <= '0;
    end else if (open_w) begin
      tmo_q <= tmo_q + 1'b1;
    end else begin
      tmo_q <= '0;
    end
  end

  a_r2_top_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_v_i && in_idx_i == IDX_TOP) |=> (mask_q == '0));

  a_r3_back_reopens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_v_i && |mask_q && in_idx_i <= last_q && in_idx_i != IDX_TOP)
      |=> (mask_q == (slot_mask_t'(1) << $past(in_idx_i))));
endmodule

// File: rtl/frag_emitter.sv
module frag_emitter
  import frag_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                close_i,
  input  slot_mask_t          cmask_i,
  input  logic [FRAGS*W-1:0]  cdata_i,
  input  logic                flag_en_i,
  output logic                pkt_valid_o,
  output logic [FRAGS*W-1:0]  pkt_data_o,
  output slot_mask_t          pkt_flag_o,
  output logic [ADD_W-1:0]    add_o
);
  logic complete, fwd;
  logic [ADD_W-1:0] missing;
  logic [FRAGS*W-1:0] filled;

  assign complete = &cmask_i;
  assign missing  = ADD_W'(FRAGS) - popcnt(cmask_i);
  assign fwd      = close_i && (complete || flag_en_i);

  always_comb begin
    add_o = '0;
    if (close_i && !complete) add_o = flag_en_i ? missing : ADD_W'(FRAGS);
  end

  for (genvar k = 0; k < FRAGS; k++) begin : g_fill
    assign filled[k*W +: W] = cmask_i[k] ? cdata_i[k*W +: W] : {W{1'b1}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pkt_valid_o <= 1'b0;
      pkt_data_o  <= '0;
      pkt_flag_o  <= '0;
    end else begin
      pkt_valid_o <= fwd;
      if (fwd) begin
        pkt_data_o <= filled;
        pkt_flag_o <= ~cmask_i;
      end
    end
  end

  a_r5_discard_no_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && !$past(flag_en_i)) |-> (pkt_flag_o == '0));
endmodule

// File: rtl/frag_counter.sv
module frag_counter
  import frag_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter bit          ENABLE = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_i,
  input  logic [ADD_W-1:0]   add_i,
  output logic [CNT_W-1:0]   cnt_o
);
  if (ENABLE) begin : g_cnt
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   sum;

    assign sum   = {1'b0, (rd_i ? '0 : cnt_q)} + (CNT_W+1)'(add_i);
    assign cnt_o = cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
    end

    a_r9_sat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == {CNT_W{1'b1}} && !rd_i) |=> (cnt_q == {CNT_W{1'b1}}));

    a_r8_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_i |=> (cnt_q == CNT_W'($past(add_i))));
  end else begin : g_off
    logic unused_in;
    assign unused_in = ^{clk_i, rst_ni, rd_i, add_i};
    assign cnt_o = '0;
  end
endmodule

// File: rtl/frag_filter.sv
module frag_filter
  import frag_pkg::*;
#(
  parameter int unsigned W           = 16,
  parameter int unsigned TMO_CYC     = 64,
  parameter int unsigned CNT_W       = 32,
  parameter bit          FINAL_STAGE = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frag_valid_i,
  input  logic [2:0]          frag_idx_i,
  input  logic [W-1:0]        frag_data_i,
  input  logic                flag_en_i,
  output logic                pkt_valid_o,
  output logic [8*W-1:0]      pkt_data_o,
  output logic [7:0]          pkt_flag_o,
  input  logic                cnt_rd_i,
  output logic [CNT_W-1:0]    cnt_o
);
  logic               close;
  slot_mask_t         cmask;
  logic [FRAGS*W-1:0] cdata;
  logic [ADD_W-1:0]   add;

  frag_collector #(.W(W), .TMO_CYC(TMO_CYC)) u_coll (
    .clk_i, .rst_ni,
    .in_v_i(frag_valid_i), .in_idx_i(frag_idx_i), .in_data_i(frag_data_i),
    .close_o(close), .cmask_o(cmask), .cdata_o(cdata)
  );

  frag_emitter #(.W(W)) u_emit (
    .clk_i, .rst_ni,
    .close_i(close), .cmask_i(cmask), .cdata_i(cdata), .flag_en_i,
    .pkt_valid_o, .pkt_data_o, .pkt_flag_o, .add_o(add)
  );

  frag_counter #(.CNT_W(CNT_W), .ENABLE(FINAL_STAGE)) u_cnt (
    .clk_i, .rst_ni, .rd_i(cnt_rd_i), .add_i(add), .cnt_o
  );
endmodule

// File: tb/tb_frag_filter.sv
`timescale 1ns/1ps
module tb_frag_filter;
  localparam int W = 16;
  localparam int TMO = 4;
  localparam int CW = 5;
  localparam logic [CW-1:0] CMAX = '1;
  // {mode, presence mask}
  localparam logic [8:0] VEC [9] = '{9'h0ff, 9'h1ff, 9'h07f, 9'h17f, 9'h181,
                                     9'h00f, 9'h180, 9'h155, 9'h0aa};

  logic clk = 0, rst_n = 0;
  logic fv = 0, fl = 0, rd = 0;
  logic [2:0] fidx = 0;
  logic [W-1:0] fdat = 0;
  logic pv, pv_nf;
  logic [8*W-1:0] pd, pd_nf;
  logic [7:0] pf, pf_nf;
  logic [CW-1:0] cnt, cnt_nf;

  int errors = 0, checks = 0;
  bit done = 0;
  logic got;
  logic [8*W-1:0] gdata;
  logic [7:0] gflag;

  always #2 clk = ~clk;

  frag_filter #(.W(W), .TMO_CYC(TMO), .CNT_W(CW), .FINAL_STAGE(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .frag_valid_i(fv), .frag_idx_i(fidx), .frag_data_i(fdat),
    .flag_en_i(fl), .pkt_valid_o(pv), .pkt_data_o(pd), .pkt_flag_o(pf),
    .cnt_rd_i(rd), .cnt_o(cnt));

  frag_filter #(.W(W), .TMO_CYC(TMO), .CNT_W(CW), .FINAL_STAGE(1'b0)) dut_nf (
    .clk_i(clk), .rst_ni(rst_n), .frag_valid_i(fv), .frag_idx_i(fidx), .frag_data_i(fdat),
    .flag_en_i(fl), .pkt_valid_o(pv_nf), .pkt_data_o(pd_nf), .pkt_flag_o(pf_nf),
    .cnt_rd_i(rd), .cnt_o(cnt_nf));

  task automatic chk(input bit ok, input string req, input logic [8*W-1:0] act, input logic [8*W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic [2:0] idx, input logic [W-1:0] d, input logic r);
    @(negedge clk);
    fv = v; fidx = idx; fdat = d; rd = r;
    @(posedge clk);
    #1;
    if (pv) begin got = 1; gdata = pd; gflag = pf; end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, '0, 1'b0);
  endtask

  task automatic read_clear(input string req);
    cyc(1'b0, 3'd0, '0, 1'b1);
    chk(cnt == 0, req, 128'(cnt), 0);
  endtask

  initial begin
    got = 0; gdata = '0; gflag = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(pv == 0, "R11 no packet in reset", 128'(pv), 0);
    chk(cnt == 0, "R11 counter zero in reset", 128'(cnt), 0);
    @(negedge clk); rst_n = 1;
    idle(2);
    chk(got == 0, "R11 no packet after reset", 128'(got), 0);

    // vector table walk: R1 R2 R4 R5 R6
    for (int e = 0; e < 9; e++) begin
      logic md;
      logic [7:0] m;
      logic [8*W-1:0] exp_d;
      logic cmpl, exp_v;
      logic [CW-1:0] exp_c;
      md = VEC[e][8]; m = VEC[e][7:0];
      cmpl = (m == 8'hff);
      exp_v = cmpl || md;
      exp_c = cmpl ? 0 : (md ? CW'(8 - $countones(m)) : CW'(8));
      for (int k = 0; k < 8; k++)
        exp_d[k*W +: W] = m[k] ? W'(e*16 + k + 1) : {W{1'b1}};
      got = 0;
      fl = md;
      for (int k = 0; k < 8; k++)
        if (m[k]) cyc(1'b1, 3'(k), W'(e*16 + k + 1), 1'b0);
      if (!m[7]) idle(TMO);
      chk(got == exp_v, "R5/R6 packet forwarded or dropped", 128'(got), 128'(exp_v));
      if (exp_v) begin
        chk(gdata == exp_d, "R1/R6 packet slots", gdata, exp_d);
        chk(gflag == (md ? ~m : 8'h00), "R5/R6 flag mask", 128'(gflag), 128'(md ? ~m : 8'h00));
      end
      chk(cnt == exp_c, "R5/R6 counter increment", 128'(cnt), 128'(exp_c));
      read_clear("R8 read clears");
    end

    // R10: non-final stage forwards identically but never counts
    chk(cnt_nf == 0, "R10 non-final count", 128'(cnt_nf), 0);
    chk(pd_nf == pd && pf_nf == pf, "R10 non-final packet", pd_nf, pd);

    // R3: backward index closes group early
    fl = 1; got = 0;
    cyc(1'b1, 3'd0, 16'h00a0, 1'b0);
    cyc(1'b1, 3'd1, 16'h00a1, 1'b0);
    cyc(1'b1, 3'd2, 16'h00a2, 1'b0);
    chk(got == 0, "R3 no close before backward index", 128'(got), 0);
    cyc(1'b1, 3'd1, 16'h00b1, 1'b0);
    chk(pv == 1, "R3 close on the backward fragment edge", 128'(pv), 1);
    chk(gflag == 8'hf8, "R3 closed group flags", 128'(gflag), 128'h f8);
    chk(gdata[3*W-1:0] == {16'h00a2, 16'h00a1, 16'h00a0}, "R3 closed group data",
        128'(gdata[3*W-1:0]), 128'({16'h00a2, 16'h00a1, 16'h00a0}));
    chk(cnt == 5, "R3 count after early close", 128'(cnt), 5);
    got = 0;
    for (int k = 2; k < 8; k++) cyc(1'b1, 3'(k), W'(16'h00b0 + k), 1'b0);
    chk(got == 1 && gflag == 8'h01, "R3 new group starts at backward fragment", 128'(gflag), 128'h01);
    chk(gdata[2*W-1:W] == 16'h00b1, "R3 new group keeps backward fragment", 128'(gdata[2*W-1:W]), 128'h00b1);
    chk(cnt == 6, "R6 count accumulates", 128'(cnt), 6);
    read_clear("R8 read clears");

    // R4: exact timeout edge
    got = 0;
    cyc(1'b1, 3'd0, 16'h0c00, 1'b0);
    idle(TMO - 1);
    chk(got == 0, "R4 no close before timeout", 128'(got), 0);
    idle(1);
    chk(pv == 1 && gflag == 8'hfe, "R4 close on timeout edge", 128'(gflag), 128'hfe);
    chk(cnt == 7, "R4 timeout count", 128'(cnt), 7);
    read_clear("R8 read clears");

    // R7: mode taken at close time
    fl = 1; got = 0;
    for (int k = 0; k < 6; k++) cyc(1'b1, 3'(k), W'(k), 1'b0);
    fl = 0;
    idle(TMO);
    chk(got == 0, "R7 dropped under mode at close", 128'(got), 0);
    chk(cnt == 8, "R7 discard count", 128'(cnt), 8);
    read_clear("R8 read clears");

    // R9: saturation via equal-index closes in discard mode
    fl = 0;
    cyc(1'b1, 3'd3, 16'h0033, 1'b0);
    for (int g = 1; g <= 5; g++) begin
      logic [CW-1:0] ec;
      cyc(1'b1, 3'd3, 16'h0033, 1'b0);
      ec = (g * 8 > 31) ? CMAX : CW'(g * 8);
      chk(cnt == ec, "R9 saturating discard count", 128'(cnt), 128'(ec));
    end
    chk(cnt_nf == 0, "R10 non-final stays zero", 128'(cnt_nf), 0);
    // R8: read coinciding with a drop
    chk(cnt == CMAX, "R8 value visible during read", 128'(cnt), 128'(CMAX));
    cyc(1'b1, 3'd3, 16'h0033, 1'b1);
    chk(cnt == 8, "R8 read keeps same-cycle increment", 128'(cnt), 8);
    idle(TMO);
    chk(cnt == 16, "R4 timeout after equal index", 128'(cnt), 16);
    read_clear("R8 read clears");

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule